// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a cache's request queue and guards store-conditional writes. It holds a single reservation made of a valid flag, a cache-line address and the identifier of the requester that owns it. The reservation is armed when a locked (load-linked) read completes and returns its line. It is not armed when that read is issued.

Every request offered for issue passes through the monitor in the same cycle, before anything else in the queue can be serviced. Plain loads, plain stores and locked reads are always let through. A locked (store-conditional) write is let through only if the reservation is valid and matches both its line and its requester identifier. A successful locked write clears the reservation as it goes out. A failed one is held back and reports a distinct failure code. An invalidate or snoop that names the reserved line also removes the reservation.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted and right after it, no reservation exists, so every locked write fails.
- R2: Requests of kind load (`req_kind_i`=0), store (1) or locked read (2) give `issue_o`=1 and `result_o`=0 in the same cycle, and leave the reservation unchanged.
- R3: A locked-read completion (`fill_valid_i`) arms the reservation with its line and owner from the next cycle on. Issuing a locked read does not arm it.
- R4: A locked write (`req_kind_i`=3) gives `issue_o`=1 and `result_o`=0 in the same cycle only when the reservation is valid and both its line and its owner equal those of the request.
- R5: A locked write that fails gives `issue_o`=0 and `result_o` equal to -2 in two's complement (8'hFE for an 8-bit result).
- R6: A successful locked write clears the reservation, so a repeat of the same locked write fails.
- R7: A failed locked write leaves the reservation unchanged.
- R8: A snoop on the reserved line clears the reservation. A snoop on any other line has no effect on it.
- R9: A new locked-read completion replaces any existing reservation.
- R10: When a completion and a locked write occur in the same cycle, the write is judged against the reservation as it stood before that cycle, and the new completion's reservation is kept afterwards.
- R11: When a completion and a snoop on the same line occur in the same cycle, the completion wins and the reservation stays armed.
- R12: With no request valid, `issue_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Locked-read completion event |
| fill_line_i | input | LINE_W | Line address of the completion |
| fill_owner_i | input | ID_W | Requester identifier of the completion |
| req_valid_i | input | 1 | Request offered for issue |
| req_kind_i | input | 2 | 0 load, 1 store, 2 locked read, 3 locked write |
| req_line_i | input | LINE_W | Line address of the request |
| req_owner_i | input | ID_W | Requester identifier of the request |
| snoop_valid_i | input | 1 | External invalidate or snoop |
| snoop_line_i | input | LINE_W | Line address of the snoop |
| issue_o | output | 1 | Request may enter the cache queue |
| result_o | output | RES_W | 0 on pass, -2 on locked-write failure |

## Verification
The hardest cases to reach are collisions in one cycle: a completion arriving together with a locked write, or together with a snoop on the same line. In each case the result depends on which update has priority and on whether the check sees the old state. The bench drives both events in the same cycle and then probes the reservation with a follow-up locked write. It also sweeps every line and owner against several reservations, so that each near miss on line or owner is shown to fail without disturbing the reservation.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_LL    = 2'd2,
    KIND_SC    = 2'd3
  } req_kind_e;
endpackage

// File: rtl/rsv_match.sv
module rsv_match #(
  parameter int LINE_W      = 26,
  parameter int ID_W        = 4,
  parameter bit CHECK_OWNER = 1'b1
) (
  input  logic              rsv_valid_i,
  input  logic [LINE_W-1:0] rsv_line_i,
  input  logic [ID_W-1:0]   rsv_owner_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic [ID_W-1:0]   cmp_owner_i,
  output logic              hit_o
);
  logic line_eq, owner_eq;

  assign line_eq  = (rsv_line_i == cmp_line_i);
  assign owner_eq = (rsv_owner_i == cmp_owner_i);

  generate
    if (CHECK_OWNER) begin : g_full
      assign hit_o = rsv_valid_i && line_eq && owner_eq;
    end else begin : g_line
      assign hit_o = rsv_valid_i && line_eq && (owner_eq || 1'b1);
    end
  endgenerate
endmodule

// File: rtl/rsv_gate.sv
module rsv_gate #(
  parameter int RES_W = 8
) (
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic             sc_hit_i,
  output logic             issue_o,
  output logic [RES_W-1:0] result_o,
  output logic             sc_pass_o
);
  import rsv_pkg::*;

  localparam logic [RES_W-1:0] FailCode = ~(RES_W'(1));  // -2

  logic is_sc;

  always_comb begin
    is_sc     = req_valid_i && (req_kind_i == KIND_SC);
    sc_pass_o = is_sc && sc_hit_i;
    issue_o   = req_valid_i && (!is_sc || sc_hit_i);
    result_o  = (is_sc && !sc_hit_i) ? FailCode : '0;
  end
endmodule

// File: rtl/rsv_state.sv
module rsv_state #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic [ID_W-1:0]   set_owner_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [ID_W-1:0]   owner_o
);
  // set has priority: the newest completion survives any same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      owner_o <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      line_o  <= set_line_i;
      owner_o <= set_owner_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4,
  parameter int RES_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic [ID_W-1:0]   fill_owner_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_owner_i,
  input  logic              snoop_valid_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output logic              issue_o,
  output logic [RES_W-1:0]  result_o
);
  logic              rsv_valid;
  logic [LINE_W-1:0] rsv_line;
  logic [ID_W-1:0]   rsv_owner;
  logic              sc_hit, snoop_hit, sc_pass;

  rsv_match #(.LINE_W(LINE_W), .ID_W(ID_W), .CHECK_OWNER(1'b1)) u_sc_match (
    .rsv_valid_i(rsv_valid), .rsv_line_i(rsv_line), .rsv_owner_i(rsv_owner),
    .cmp_line_i(req_line_i), .cmp_owner_i(req_owner_i), .hit_o(sc_hit)
  );

  rsv_match #(.LINE_W(LINE_W), .ID_W(ID_W), .CHECK_OWNER(1'b0)) u_snoop_match (
    .rsv_valid_i(rsv_valid && snoop_valid_i), .rsv_line_i(rsv_line), .rsv_owner_i(rsv_owner),
    .cmp_line_i(snoop_line_i), .cmp_owner_i(rsv_owner), .hit_o(snoop_hit)
  );

  rsv_gate #(.RES_W(RES_W)) u_gate (
    .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .sc_hit_i(sc_hit),
    .issue_o(issue_o), .result_o(result_o), .sc_pass_o(sc_pass)
  );

  rsv_state #(.LINE_W(LINE_W), .ID_W(ID_W)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(fill_valid_i), .set_line_i(fill_line_i), .set_owner_i(fill_owner_i),
    .clr_i(sc_pass || snoop_hit),
    .valid_o(rsv_valid), .line_o(rsv_line), .owner_o(rsv_owner)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4,
  parameter int RES_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fill_valid_i,
  input logic [LINE_W-1:0] fill_line_i,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic [LINE_W-1:0] req_line_i,
  input logic [ID_W-1:0]   req_owner_i,
  input logic              snoop_valid_i,
  input logic [LINE_W-1:0] snoop_line_i,
  input logic              issue_o,
  input logic [RES_W-1:0]  result_o,
  input logic              rsv_valid,
  input logic [LINE_W-1:0] rsv_line,
  input logic [ID_W-1:0]   rsv_owner
);
  localparam logic [RES_W-1:0] FailCode = ~(RES_W'(1));
  logic is_sc;
  assign is_sc = req_valid_i && (req_kind_i == 2'd3);

  AST_PLAIN_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !is_sc |-> issue_o && result_o == '0); // R2
  AST_FILL_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> rsv_valid && rsv_line == $past(fill_line_i)); // R3
  AST_NO_SELF_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i && !rsv_valid |=> !rsv_valid); // R3
  AST_SC_NEEDS_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && issue_o |-> rsv_valid && rsv_line == req_line_i && rsv_owner == req_owner_i); // R4
  AST_FAIL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && !issue_o |-> result_o == FailCode); // R5
  AST_FAIL_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o == FailCode |-> !issue_o); // R5
  AST_SC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && issue_o && !fill_valid_i |=> !rsv_valid); // R6
  AST_SNOOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i && rsv_valid && snoop_line_i == rsv_line && !fill_valid_i |=> !rsv_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !issue_o && result_o == '0); // R12
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W), .RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i),
  .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
  .req_line_i(req_line_i), .req_owner_i(req_owner_i),
  .snoop_valid_i(snoop_valid_i), .snoop_line_i(snoop_line_i),
  .issue_o(issue_o), .result_o(result_o),
  .rsv_valid(rsv_valid), .rsv_line(rsv_line), .rsv_owner(rsv_owner)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int LINE_W = 6;
  localparam int ID_W   = 2;
  localparam int RES_W  = 8;
  localparam int NLINE  = 1 << LINE_W;
  localparam int NOWN   = 1 << ID_W;
  localparam logic [RES_W-1:0] FAIL_V = 8'hFE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 0, rv = 0, sv = 0;
  logic [LINE_W-1:0] fl = '0, rl = '0, sl = '0;
  logic [ID_W-1:0] fo = '0, ro = '0;
  logic [1:0] rk = '0;
  logic issue;
  logic [RES_W-1:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  llsc_monitor #(.LINE_W(LINE_W), .ID_W(ID_W), .RES_W(RES_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fv), .fill_line_i(fl), .fill_owner_i(fo),
    .req_valid_i(rv), .req_kind_i(rk), .req_line_i(rl), .req_owner_i(ro),
    .snoop_valid_i(sv), .snoop_line_i(sl),
    .issue_o(issue), .result_o(res)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // set every input at the falling edge, settle, return before the rising edge
  task automatic apply(input logic f_v, input int f_l, input int f_o,
                       input logic r_v, input int r_k, input int r_l, input int r_o,
                       input logic s_v, input int s_l);
    @(negedge clk);
    fv = f_v; fl = LINE_W'(f_l); fo = ID_W'(f_o);
    rv = r_v; rk = 2'(r_k); rl = LINE_W'(r_l); ro = ID_W'(r_o);
    sv = s_v; sl = LINE_W'(s_l);
    #1;
  endtask

  task automatic idle();
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int l, input int o);
    apply(1, l, o, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic sc(input int l, input int o, input bit ok, input string req);
    apply(0, 0, 0, 1, 3, l, o, 0, 0);
    chk(req, issue, ok);
    chk(ok ? req : "R5", res, ok ? 0 : FAIL_V);
  endtask

  initial begin
    // R1: during reset
    rv = 1; rk = 2'd3; rl = '0; ro = '0;
    #3;
    chk("R1", issue, 0);
    chk("R1", res, FAIL_V);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < NLINE; l += 7) sc(l, l % NOWN, 0, "R1");

    // R12: idle
    idle();
    chk("R12", issue, 0);
    chk("R12", res, 0);

    // R2: plain kinds always issue
    for (int k = 0; k < 3; k++)
      for (int l = 0; l < NLINE; l += 9) begin
        apply(0, 0, 0, 1, k, l, k, 0, 0);
        chk("R2", issue, 1);
        chk("R2", res, 0);
      end

    // R3: issuing a locked read does not arm
    apply(0, 0, 0, 1, 2, 17, 1, 0, 0);
    idle();
    sc(17, 1, 0, "R3");

    // R4/R6/R7: sweep all lines and owners against several reservations
    for (int t = 0; t < 3; t++) begin
      int tl, tow;
      tl = (t == 0) ? 5 : (t == 1) ? NLINE - 1 : 0;
      tow = (t == 0) ? 1 : (t == 1) ? NOWN - 1 : 0;
      fill(tl, tow);
      for (int l = 0; l < NLINE; l++)
        for (int o = 0; o < NOWN; o++)
          if (!(l == tl && o == tow)) sc(l, o, 0, "R7");
      sc(tl, tow, 1, "R4");
      sc(tl, tow, 0, "R6");
    end

    // R8: snoop on other line keeps, on reserved line clears
    fill(9, 2);
    apply(0, 0, 0, 0, 0, 0, 0, 1, 10);
    sc(9, 2, 1, "R8");
    fill(9, 2);
    apply(0, 0, 0, 0, 0, 0, 0, 1, 9);
    sc(9, 2, 0, "R8");

    // R9: overwrite
    fill(3, 1);
    fill(4, 2);
    sc(3, 1, 0, "R9");
    sc(4, 2, 1, "R9");

    // R10: same-cycle completion and locked write use old state
    fill(7, 0);
    apply(1, 8, 1, 1, 3, 7, 0, 0, 0);
    chk("R10", issue, 1);
    chk("R10", res, 0);
    sc(8, 1, 1, "R10");
    apply(1, 20, 1, 1, 3, 20, 1, 0, 0);
    chk("R10", issue, 0);
    chk("R10", res, FAIL_V);
    sc(20, 1, 1, "R10");

    // R11: completion beats snoop on same line
    apply(1, 30, 2, 0, 0, 0, 0, 1, 30);
    sc(30, 2, 1, "R11");

    // R2: plain traffic to the reserved line leaves reservation
    fill(12, 3);
    apply(0, 0, 0, 1, 1, 12, 0, 0, 0);
    apply(0, 0, 0, 1, 0, 12, 3, 0, 0);
    apply(0, 0, 0, 1, 2, 12, 1, 0, 0);
    sc(12, 3, 1, "R2");

    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule